// File: doc/BRIEF.md
# Fuse Array Command Sequencer

This block is a register-mapped controller that sits between software and a one-time-programmable fuse array. Software first requests power for the array through a configuration bit and waits until the status register reports that the array is powered. It then issues one command at a time through a control register: reload a fuse word into its shadow copy, burn the write-data register into a fuse word, or run either operation on the separate permanent-lock plane. A busy flag covers each operation until the array reports completion.

Results come back through status flags and per-word bitmaps. Each fuse word has an error bit and a disturbed bit, packed 32 to a register, with consecutive registers for consecutive banks. A shadow RAM holds one 32-bit word per fuse word. Software may read and overwrite the shadow RAM freely, and doing so never reaches the fuses. When the device reports an invalid security state, the controller refuses every command and every shadow access.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset, the configuration register reads 0, busy and program-fail are 0, and all error and disturbed bits are 0. Status bit 0 mirrors `mode_secure`, bit 2 mirrors `mode_invalid` and bit 8 mirrors `mode_closed`. Every other status bit reads 0 except bits 3, 4 and 5, which are defined in R2, R3 and R6.
- R2: Bit 0 of the configuration register (offset 0x000) drives `fz_pwr_req`. Status bit 5 (offset 0x00C) shows `fz_pwr_ack` one cycle late, so it rises after the array acknowledges the request and falls again once the request is cleared.
- R3: A write to the control register (offset 0x004) carries the word index in bits [IDX_W-1:0]. Bit 8 selects program and bit 9 selects the lock plane. The command is accepted only while the array is powered, the sequencer is idle and the invalid mode is off. Status bit 3 (busy) is set from the cycle after the write until the cycle after `fz_done`.
- R4: A control write that is in range and not blocked, but arrives while busy or while the array is unpowered, is dropped. It starts nothing and sets the error bit of the index it carries.
- R5: An accepted non-lock command clears its word's error and disturbed bits. When a reload completes, `fz_ecc` decides the outcome. A value of 0 copies the fuse word into the shadow. A value of 1 also copies the word and sets the disturbed bit. A value of 2 sets the error bit and leaves the shadow word unchanged.
- R6: A program burns the write-data register (offset 0x008) into the addressed word. If `fz_fail` is high at completion, status bit 4 is set, and it stays set until the next accepted command.
- R7: Error bits sit at offset 0x010 + 4*(id>>5) and disturbed bits at offset 0x030 + 4*(id>>5), with bit position id & 31.
- R8: Shadow word id sits at offset 0x200 + 4*id. Software writes there change only the shadow copy.
- R9: A lock-plane program burns the write-data register into the lock row named by the index field. A lock-plane reload loads the row into the write-data register and touches neither the shadow nor the flags. Software names the row and data itself. A lower word id uses row id/8 with data 3<<((2*id)&15). An upper word uses row UPPER_BASE/8 + (id-UPPER_BASE)/16 with data 1<<(id&15).
- R10: A control write whose index is at least NUM_WORDS, or at least the lock row count for a lock-plane command, is ignored without setting any flag.
- R11: While `mode_invalid` is high, control writes and shadow writes are ignored and shadow reads return 0.
- R12: A read returns its data with `host_rvalid` on the cycle after the request. Unmapped or misaligned offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data |
| host_rvalid | output | 1 | Read data valid |
| mode_secure | input | 1 | Device secure state |
| mode_invalid | input | 1 | Device invalid state, blocks access |
| mode_closed | input | 1 | Device closed state |
| fz_pwr_req | output | 1 | Array power request |
| fz_pwr_ack | input | 1 | Array power acknowledge |
| fz_start | output | 1 | One-cycle operation start |
| fz_prog | output | 1 | Operation is a program |
| fz_lock | output | 1 | Operation targets the lock plane |
| fz_idx | output | IDX_W | Word or lock-row index |
| fz_wdata | output | 32 | Data to burn |
| fz_done | input | 1 | Operation complete pulse |
| fz_rdata | input | 32 | Word read from the array |
| fz_ecc | input | 2 | Read check: 0 clean, 1 corrected, 2 uncorrectable |
| fz_fail | input | 1 | Program failure at completion |

## Verification
A sequencer stuck in a busy state shows up one cycle later as status bit 3 staying high, and every later control write then turns into a rejection with a stray error bit. An error or disturbed bit taken from the wrong index shows up on the next bank read, because the bench predicts every bank word in full. An operation whose completion goes to the wrong place corrupts a shadow word or the write-data register, and the next readback of that word exposes it. Power-state mistakes appear within a few cycles, because the bench reads status bit 5 just before and just after the acknowledge edge.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_e;

  localparam int unsigned CMD_PROG_BIT = 8;
  localparam int unsigned CMD_LOCK_BIT = 9;

  localparam int unsigned OFF_CFG    = 'h000;
  localparam int unsigned OFF_CTRL   = 'h004;
  localparam int unsigned OFF_WDATA  = 'h008;
  localparam int unsigned OFF_STATUS = 'h00C;
  localparam int unsigned OFF_ERR    = 'h010;
  localparam int unsigned OFF_DIST   = 'h030;
  localparam int unsigned OFF_SHADOW = 'h200;

  localparam logic [1:0] ECC_CLEAN = 2'd0;
  localparam logic [1:0] ECC_FIXED = 2'd1;
  localparam logic [1:0] ECC_FATAL = 2'd2;

endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_ctrl_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             cmd_prog,
  input  logic             cmd_lock,
  input  logic             cmd_in_range,
  input  logic             powered,
  input  logic             blocked,
  input  logic             fz_done,
  output logic             busy,
  output logic             cmd_accept,
  output logic             cmd_reject,
  output logic             fz_start,
  output logic             op_prog,
  output logic             op_lock,
  output logic [IDX_W-1:0] op_idx,
  output logic             cmpl_valid
);

  sq_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic             prog_q, lock_q;
  logic             live;

  always_comb begin
    busy       = (st_q != SQ_IDLE);
    live       = cmd_wr && !blocked && cmd_in_range;
    cmd_accept = live && powered && !busy;
    cmd_reject = live && (!powered || busy);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (cmd_accept) st_d = SQ_ISSUE;
      SQ_ISSUE: st_d = SQ_WAIT;
      SQ_WAIT:  if (fz_done) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      prog_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (cmd_accept) begin
      idx_q  <= cmd_idx;
      prog_q <= cmd_prog;
      lock_q <= cmd_lock;
    end
  end

  assign fz_start   = (st_q == SQ_ISSUE);
  assign cmpl_valid = (st_q == SQ_WAIT) && fz_done;
  assign op_prog    = prog_q;
  assign op_lock    = lock_q;
  assign op_idx     = idx_q;

endmodule

// File: rtl/fuse_flags.sv
module fuse_flags #(
  parameter int unsigned NUM_WORDS = 96,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned BANKS     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_en,
  input  logic [IDX_W-1:0]      clr_idx,
  input  logic                  rej_en,
  input  logic [IDX_W-1:0]      rej_idx,
  input  logic                  hw_err_en,
  input  logic                  hw_dist_en,
  input  logic [IDX_W-1:0]      hw_idx,
  output logic [BANKS*32-1:0]   err_flat,
  output logic [BANKS*32-1:0]   dist_flat
);

  for (genvar w = 0; w < BANKS*32; w++) begin : g_word
    if (w < NUM_WORDS) begin : g_live
      logic err_q, err_d, dist_q, dist_d, upd_en;
      logic hit_clr, hit_rej, hit_hw;

      always_comb begin
        hit_clr = clr_en && (clr_idx == IDX_W'(w));
        hit_rej = rej_en && (rej_idx == IDX_W'(w));
        hit_hw  = hw_idx == IDX_W'(w);
        upd_en  = hit_clr || hit_rej || (hit_hw && (hw_err_en || hw_dist_en));
        err_d   = (err_q && !hit_clr) || hit_rej || (hit_hw && hw_err_en);
        dist_d  = (dist_q && !hit_clr) || (hit_hw && hw_dist_en);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          err_q  <= 1'b0;
          dist_q <= 1'b0;
        end else if (upd_en) begin
          err_q  <= err_d;
          dist_q <= dist_d;
        end
      end

      assign err_flat[w]  = err_q;
      assign dist_flat[w] = dist_q;
    end else begin : g_pad
      assign err_flat[w]  = 1'b0;
      assign dist_flat[w] = 1'b0;
    end
  end

endmodule

// File: rtl/fuse_shadow.sv
module fuse_shadow #(
  parameter int unsigned NUM_WORDS = 96,
  parameter int unsigned IDX_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_we,
  input  logic [IDX_W-1:0] hw_idx,
  input  logic [31:0]      hw_data,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [31:0]      sw_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);

  logic [31:0] mem_q [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_ent
    logic        hw_hit, sw_hit, ent_en;
    logic [31:0] ent_d;

    always_comb begin
      hw_hit = hw_we && (hw_idx == IDX_W'(w));
      sw_hit = sw_we && (sw_idx == IDX_W'(w));
      ent_en = hw_hit || sw_hit;
      ent_d  = hw_hit ? hw_data : sw_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[w] <= '0;
      else if (ent_en) mem_q[w] <= ent_d;
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_ctrl_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 96,
  parameter int unsigned UPPER_BASE = 32,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_sel,
  input  logic                          host_wr,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [31:0]                   host_wdata,
  output logic [31:0]                   host_rdata,
  output logic                          host_rvalid,
  input  logic                          mode_secure,
  input  logic                          mode_invalid,
  input  logic                          mode_closed,
  output logic                          fz_pwr_req,
  input  logic                          fz_pwr_ack,
  output logic                          fz_start,
  output logic                          fz_prog,
  output logic                          fz_lock,
  output logic [$clog2(NUM_WORDS)-1:0]  fz_idx,
  output logic [31:0]                   fz_wdata,
  input  logic                          fz_done,
  input  logic [31:0]                   fz_rdata,
  input  logic [1:0]                    fz_ecc,
  input  logic                          fz_fail
);

  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
  localparam int unsigned BANKS     = (NUM_WORDS + 31) / 32;
  localparam int unsigned BANK_W    = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int unsigned LOCK_ROWS = UPPER_BASE / 8 + (NUM_WORDS - UPPER_BASE) / 16;
  localparam int unsigned WA_W      = ADDR_W - 2;

  localparam logic [WA_W-1:0] CFG_WA  = WA_W'(OFF_CFG >> 2);
  localparam logic [WA_W-1:0] CTRL_WA = WA_W'(OFF_CTRL >> 2);
  localparam logic [WA_W-1:0] WD_WA   = WA_W'(OFF_WDATA >> 2);
  localparam logic [WA_W-1:0] ST_WA   = WA_W'(OFF_STATUS >> 2);
  localparam logic [WA_W-1:0] ERR_WA  = WA_W'(OFF_ERR >> 2);
  localparam logic [WA_W-1:0] DIST_WA = WA_W'(OFF_DIST >> 2);
  localparam logic [WA_W-1:0] SH_WA   = WA_W'(OFF_SHADOW >> 2);

  // address decode
  logic            aligned;
  logic [WA_W-1:0] waddr, err_rel, dist_rel, sh_rel;
  logic            err_hit, dist_hit, sh_hit;
  logic [BANK_W-1:0] err_sel, dist_sel;
  logic [IDX_W-1:0]  sh_idx;
  logic            rd_req, cfg_wr, ctrl_wr, wd_wr, sh_wr;

  always_comb begin
    aligned  = (host_addr[1:0] == 2'b00);
    waddr    = host_addr[ADDR_W-1:2];
    err_rel  = waddr - ERR_WA;
    dist_rel = waddr - DIST_WA;
    sh_rel   = waddr - SH_WA;
    err_hit  = aligned && (waddr >= ERR_WA) && (err_rel < WA_W'(BANKS));
    dist_hit = aligned && (waddr >= DIST_WA) && (dist_rel < WA_W'(BANKS));
    sh_hit   = aligned && (waddr >= SH_WA) && (sh_rel < WA_W'(NUM_WORDS));
    err_sel  = err_rel[BANK_W-1:0];
    dist_sel = dist_rel[BANK_W-1:0];
    sh_idx   = sh_rel[IDX_W-1:0];
    rd_req   = host_sel && !host_wr;
    cfg_wr   = host_sel && host_wr && aligned && (waddr == CFG_WA);
    ctrl_wr  = host_sel && host_wr && aligned && (waddr == CTRL_WA);
    wd_wr    = host_sel && host_wr && aligned && (waddr == WD_WA);
    sh_wr    = host_sel && host_wr && sh_hit && !mode_invalid;
  end

  // command decode
  logic [IDX_W-1:0] cmd_idx;
  logic             cmd_prog, cmd_lock, cmd_in_range;

  always_comb begin
    cmd_idx      = host_wdata[IDX_W-1:0];
    cmd_prog     = host_wdata[CMD_PROG_BIT];
    cmd_lock     = host_wdata[CMD_LOCK_BIT];
    cmd_in_range = cmd_lock ? ({1'b0, cmd_idx} < (IDX_W+1)'(LOCK_ROWS))
                            : ({1'b0, cmd_idx} < (IDX_W+1)'(NUM_WORDS));
  end

  // state registers
  logic        cfg_q, cfg_d, pwr_ok_q;
  logic [31:0] wdata_q, wdata_d;
  logic        wdata_en;
  logic        pf_q, pf_d, pf_en;

  logic             seq_busy, cmd_accept, cmd_reject, cmpl_valid;
  logic             op_prog, op_lock;
  logic [IDX_W-1:0] op_idx;

  fuse_seq #(.IDX_W(IDX_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (ctrl_wr),
    .cmd_idx      (cmd_idx),
    .cmd_prog     (cmd_prog),
    .cmd_lock     (cmd_lock),
    .cmd_in_range (cmd_in_range),
    .powered      (pwr_ok_q),
    .blocked      (mode_invalid),
    .fz_done      (fz_done),
    .busy         (seq_busy),
    .cmd_accept   (cmd_accept),
    .cmd_reject   (cmd_reject),
    .fz_start     (fz_start),
    .op_prog      (op_prog),
    .op_lock      (op_lock),
    .op_idx       (op_idx),
    .cmpl_valid   (cmpl_valid)
  );

  // completion routing
  logic reload_done, lockrd_done, prog_done;

  always_comb begin
    reload_done = cmpl_valid && !op_prog && !op_lock;
    lockrd_done = cmpl_valid && !op_prog && op_lock;
    prog_done   = cmpl_valid && op_prog;
  end

  always_comb begin
    cfg_d    = cfg_wr ? host_wdata[0] : cfg_q;
    wdata_en = lockrd_done || wd_wr;
    wdata_d  = lockrd_done ? fz_rdata : host_wdata;
    pf_en    = cmd_accept || prog_done;
    pf_d     = cmd_accept ? 1'b0 : fz_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= 1'b0;
      pwr_ok_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      pwr_ok_q <= fz_pwr_ack;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= wdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pf_q <= 1'b0;
    else if (pf_en) pf_q <= pf_d;
  end

  // flags and shadow
  logic [BANKS*32-1:0] err_flat, dist_flat;
  logic [31:0]         err_words [BANKS];
  logic [31:0]         dist_words [BANKS];
  logic [31:0]         sh_rdata;

  fuse_flags #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .BANKS(BANKS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_en     (cmd_accept && !cmd_lock),
    .clr_idx    (cmd_idx),
    .rej_en     (cmd_reject),
    .rej_idx    (cmd_idx),
    .hw_err_en  (reload_done && (fz_ecc == ECC_FATAL)),
    .hw_dist_en (reload_done && (fz_ecc == ECC_FIXED)),
    .hw_idx     (op_idx),
    .err_flat   (err_flat),
    .dist_flat  (dist_flat)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign err_words[b]  = err_flat[b*32 +: 32];
    assign dist_words[b] = dist_flat[b*32 +: 32];
  end

  fuse_shadow #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_we   (reload_done && (fz_ecc != ECC_FATAL)),
    .hw_idx  (op_idx),
    .hw_data (fz_rdata),
    .sw_we   (sh_wr),
    .sw_idx  (sh_idx),
    .sw_data (host_wdata),
    .rd_idx  (sh_idx),
    .rd_data (sh_rdata)
  );

  // read path
  logic [31:0] status_w, rd_d, rdata_q;
  logic        rvalid_q;

  always_comb begin
    status_w = {23'b0, mode_closed, 2'b00, pwr_ok_q, pf_q, seq_busy,
                mode_invalid, 1'b0, mode_secure};
    rd_d = '0;
    if (aligned && waddr == CFG_WA)        rd_d = {31'b0, cfg_q};
    else if (aligned && waddr == WD_WA)    rd_d = wdata_q;
    else if (aligned && waddr == ST_WA)    rd_d = status_w;
    else if (err_hit)                      rd_d = err_words[err_sel];
    else if (dist_hit)                     rd_d = dist_words[dist_sel];
    else if (sh_hit && !mode_invalid)      rd_d = sh_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign fz_pwr_req  = cfg_q;
  assign fz_prog     = op_prog;
  assign fz_lock     = op_lock;
  assign fz_idx      = op_idx;
  assign fz_wdata    = wdata_q;

endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        pwr_ok,
  input logic        fz_pwr_ack,
  input logic        fz_start,
  input logic        fz_done,
  input logic        mode_invalid,
  input logic        host_sel,
  input logic        host_wr,
  input logic        sh_hit,
  input logic [31:0] host_rdata,
  input logic        host_rvalid
);

  // R3: the array sees a single start pulse per command
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fz_start |=> !fz_start);

  // R3: a start only happens while busy is reported
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fz_start |-> busy);

  // R3: completion returns the sequencer to idle
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fz_done && !fz_start) |=> !busy);

  // R2: powered flag drops once the acknowledge is gone
  p_pwr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fz_pwr_ack |=> !pwr_ok);

  // R4: nothing starts from idle while unpowered
  p_no_start_unpowered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok && !busy) |=> !fz_start);

  // R11: invalid mode keeps an idle sequencer idle
  p_invalid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode_invalid) |=> !busy);

  // R11: shadow reads return zero in invalid mode
  p_invalid_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && sh_hit && mode_invalid) |=> (host_rdata == 32'h0));

  // R12: each read is answered on the next cycle
  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr) |=> host_rvalid);

endmodule

bind fuse_ctrl fuse_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (seq_busy),
  .pwr_ok       (pwr_ok_q),
  .fz_pwr_ack   (fz_pwr_ack),
  .fz_start     (fz_start),
  .fz_done      (fz_done),
  .mode_invalid (mode_invalid),
  .host_sel     (host_sel),
  .host_wr      (host_wr),
  .sh_hit       (sh_hit),
  .host_rdata   (host_rdata),
  .host_rvalid  (host_rvalid)
);

// File: tb/fuse_ctrl_bench.sv
`timescale 1ns/1ps
module fuse_ctrl_bench;

  localparam int NW = 96;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_wr;
  logic [11:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        host_rvalid;
  logic        mode_secure, mode_invalid, mode_closed;
  logic        fz_pwr_req, fz_pwr_ack, fz_start, fz_prog, fz_lock;
  logic [6:0]  fz_idx;
  logic [31:0] fz_wdata, fz_rdata;
  logic        fz_done, fz_fail;
  logic [1:0]  fz_ecc;

  always #2.5 clk = ~clk;

  fuse_ctrl u_fuse_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mode_secure(mode_secure), .mode_invalid(mode_invalid), .mode_closed(mode_closed),
    .fz_pwr_req(fz_pwr_req), .fz_pwr_ack(fz_pwr_ack), .fz_start(fz_start),
    .fz_prog(fz_prog), .fz_lock(fz_lock), .fz_idx(fz_idx), .fz_wdata(fz_wdata),
    .fz_done(fz_done), .fz_rdata(fz_rdata), .fz_ecc(fz_ecc), .fz_fail(fz_fail)
  );

  // behavioural fuse array
  logic [31:0] fmem [NW];
  logic [31:0] lmem [8];
  logic [3:0]  lat, pcnt;
  logic        s_prog, s_lock;
  logic [6:0]  s_idx;
  logic [31:0] s_wd;

  function automatic logic [31:0] fz_init(int i);
    return 32'h5A00_0000 | (32'(i) << 8) | 32'(i);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) fmem[i] <= fz_init(i);
      for (int i = 0; i < 8; i++) lmem[i] <= '0;
      lat <= 0; pcnt <= 0; fz_pwr_ack <= 0; fz_done <= 0;
      fz_rdata <= 0; fz_ecc <= 0; fz_fail <= 0;
      s_prog <= 0; s_lock <= 0; s_idx <= 0; s_wd <= 0;
    end else begin
      if (fz_pwr_req != fz_pwr_ack) begin
        if (pcnt == 3) begin fz_pwr_ack <= fz_pwr_req; pcnt <= 0; end
        else pcnt <= pcnt + 1;
      end else pcnt <= 0;
      fz_done <= 1'b0;
      if (fz_start) begin
        lat <= 6; s_prog <= fz_prog; s_lock <= fz_lock; s_idx <= fz_idx; s_wd <= fz_wdata;
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          fz_done <= 1'b1; fz_ecc <= 2'd0; fz_fail <= 1'b0; fz_rdata <= 32'h0;
          if (s_prog) begin
            if (s_lock) lmem[s_idx[2:0]] <= lmem[s_idx[2:0]] | s_wd;
            else if (s_idx == 7'd20) fz_fail <= 1'b1;
            else fmem[s_idx] <= fmem[s_idx] | s_wd;
          end else begin
            fz_rdata <= s_lock ? lmem[s_idx[2:0]] : fmem[s_idx];
            if (!s_lock && s_idx == 7'd7) fz_ecc <= 2'd1;
            if (!s_lock && s_idx == 7'd9) fz_ecc <= 2'd2;
          end
        end
      end
    end
  end

  // scoreboard
  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && host_rvalid && exp_q.size() != 0) begin
      logic [31:0] e, m; string t;
      e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if ((host_rdata & m) != (e & m)) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, host_rdata & m, e & m);
      end
    end
    if (cyc > LIMIT && !done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t,
                    input logic [31:0] m = 32'hFFFF_FFFF);
    host_sel = 1; host_wr = 0; host_addr = a;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    @(negedge clk);
    host_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] sh(int i);
    return 12'(12'h200 + 4 * i);
  endfunction

  localparam logic [11:0] A_CFG = 12'h000, A_CTRL = 12'h004, A_WD = 12'h008,
                          A_ST = 12'h00C, A_E0 = 12'h010, A_E1 = 12'h014,
                          A_E2 = 12'h018, A_D0 = 12'h030, A_D2 = 12'h038;

  initial begin
    rst_n = 0; host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    mode_secure = 1; mode_invalid = 0; mode_closed = 0;
    idle(3); rst_n = 1; idle(2);

    rd(A_CFG, 32'h0, "R1 cfg reset");
    rd(A_ST,  32'h1, "R1 status reset");
    rd(A_E0,  32'h0, "R1 error reset");
    rd(A_D2,  32'h0, "R1 disturbed reset");
    mode_closed = 1;
    rd(A_ST,  32'h101, "R1 closed mirror");
    mode_closed = 0;

    wr(A_CTRL, 32'd3);
    rd(A_E0, 32'h8, "R4 reject unpowered sets error");
    rd(A_ST, 32'h1, "R4 reject starts nothing");

    wr(A_CFG, 32'h1);
    rd(A_ST, 32'h1, "R2 power not yet acknowledged");
    idle(8);
    rd(A_ST, 32'h21, "R2 powered");

    wr(A_CTRL, 32'd3);
    rd(A_ST, 32'h29, "R3 busy after accept");
    idle(12);
    rd(A_ST, 32'h21, "R3 busy cleared");
    rd(sh(3), fz_init(3), "R5 reload clean");
    rd(A_E0, 32'h0, "R5 accept clears error");

    wr(A_CTRL, 32'd5);
    wr(A_CTRL, 32'h106);
    idle(12);
    rd(A_E0, 32'h40, "R4 reject while busy");
    rd(sh(5), fz_init(5), "R5 reload word 5");
    wr(A_CTRL, 32'd6);
    idle(12);
    rd(sh(6), fz_init(6), "R4 rejected program left fuse intact");
    rd(A_E0, 32'h0, "R5 error cleared by reload");

    wr(A_CTRL, 32'd7);
    idle(12);
    rd(A_D0, 32'h80, "R5 corrected read disturbed");
    rd(sh(7), fz_init(7), "R5 corrected data stored");

    wr(sh(9), 32'h1234_5678);
    rd(sh(9), 32'h1234_5678, "R8 shadow write");
    wr(A_CTRL, 32'd9);
    idle(12);
    rd(A_E0, 32'h200, "R5 uncorrectable error");
    rd(sh(9), 32'h1234_5678, "R5 shadow kept on fatal");

    wr(sh(10), 32'hDEAD_BEEF);
    rd(sh(10), 32'hDEAD_BEEF, "R8 shadow write 10");
    wr(A_CTRL, 32'd10);
    idle(12);
    rd(sh(10), fz_init(10), "R8 fuse untouched by shadow write");

    wr(A_WD, 32'h00F0_0000);
    wr(A_CTRL, 32'h100 | 40);
    idle(12);
    rd(A_ST, 32'h21, "R6 program success");
    wr(A_CTRL, 32'd40);
    idle(12);
    rd(sh(40), fz_init(40) | 32'h00F0_0000, "R6 burned value");

    wr(A_CTRL, 32'h100 | 20);
    idle(12);
    rd(A_ST, 32'h31, "R6 program fail flag");
    wr(A_CTRL, 32'd20);
    rd(A_ST, 32'h29, "R6 fail cleared on accept");
    idle(12);
    rd(sh(20), fz_init(20), "R6 failed word unchanged");

    wr(A_WD, 32'h8);
    wr(A_CTRL, 32'h300 | 4);
    idle(12);
    wr(A_WD, 32'h0);
    wr(A_CTRL, 32'h200 | 4);
    idle(12);
    rd(A_WD, 32'h8, "R9 upper lock row readback");
    wr(A_WD, 32'hC00);
    wr(A_CTRL, 32'h300);
    idle(12);
    wr(A_WD, 32'h0);
    wr(A_CTRL, 32'h200);
    idle(12);
    rd(A_WD, 32'hC00, "R9 lower lock row readback");
    rd(sh(4), 32'h0, "R9 lock read leaves shadow");

    wr(A_CTRL, 32'd100);
    rd(A_ST, 32'h21, "R10 index beyond words ignored");
    wr(A_CTRL, 32'h200 | 8);
    rd(A_ST, 32'h21, "R10 lock row beyond range ignored");

    wr(A_CFG, 32'h0);
    idle(8);
    rd(A_ST, 32'h1, "R2 power dropped");
    wr(A_CTRL, 32'd45);
    wr(A_CTRL, 32'd70);
    rd(A_E1, 32'h2000, "R7 bank 1 bit 13");
    rd(A_E2, 32'h40, "R7 bank 2 bit 6");
    rd(A_E0, 32'h200, "R7 bank 0 unchanged");

    wr(A_CFG, 32'h1);
    idle(8);
    mode_invalid = 1;
    rd(A_ST, 32'h25, "R11 invalid status");
    rd(sh(3), 32'h0, "R11 shadow read zero");
    wr(sh(3), 32'h1111_1111);
    wr(A_CTRL, 32'd11);
    rd(A_ST, 32'h25, "R11 command blocked");
    mode_invalid = 0;
    rd(sh(3), fz_init(3), "R11 shadow write blocked");
    rd(sh(11), 32'h0, "R11 reload blocked");
    rd(A_E0, 32'h200, "R11 no error on block");
    rd(12'h201, 32'h0, "R12 misaligned reads zero");

    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule